// File: doc/BRIEF.md
# Auxiliary System Control Register Bank

A small bank of control registers that sits on a simple synchronous register bus. It holds a configuration byte, a diagnostic byte, a modem-control byte, two auxiliary bytes, a 16-bit LED word and a system-control word. A few register bits are not stored. Writing them produces a one-clock pulse to the floppy controller (terminal count) or to the reset sequencer (reset request). A sticky power-off request is raised for the power sequencer.

The block watches a power-failing status input. When that input changes, a power-fail flag is re-evaluated. The flag is set only if the power interrupt is enabled in the configuration byte. A level interrupt is raised while the flag and that enable are both set. Software clears the flag through a clear bit in the second auxiliary byte.

Each access names a region, a byte offset and a size. An access whose size or offset does not fit its region is dropped.

Top module: `aux_ctl_bank`

## Requirements
- R1: `irq_o` is high exactly when the power-fail flag is set and configuration bit 3 (power interrupt enable) is set. Both use their current register values.
- R2: On every clock where `pwr_failing_i` differs from its value at the previous clock, the flag takes the value `pwr_failing_i AND` configuration bit 3. Here bit 3 is its value before that clock. The reference value of the input after reset is 0. On that same clock the input change takes priority over an aux2 clear.
- R3: A valid write to aux1 (region 3) stores the write byte with bit 1 forced to 0. If write bit 1 is set, `tc_pulse_o` is high for exactly the next clock. Reads of aux1 always return bit 1 as 0.
- R4: A valid write to aux2 (region 4) stores write bit 0 as the power-off bit. If write bit 1 is set, it clears the flag. All other write bits are ignored. An aux2 read returns the flag in bit 5 and the power-off bit in bit 0, with all other bits 0.
- R5: A valid aux2 write with bit 0 set raises `pwr_off_o`. It stays high until reset.
- R6: A valid write to system-control (region 6) with bit 0 set stores 0x02 and pulses `reset_req_o` for exactly the next clock. A write with bit 0 clear changes nothing. Reads return the stored value.
- R7: Configuration (region 0), diagnostic (region 1) and modem-control (region 2) are plain 8-bit read/write registers. The LED register (region 5) is a plain 16-bit read/write register.
- R8: An access is valid only when `bus_offset` is 0 and `bus_size` matches the region. Byte regions 0–4 need size 0, region 5 needs size 1 and region 6 needs size 2. Region 7 is never valid. An invalid access changes nothing. `bus_rdata` is 0 except during a valid read.
- R9: Synchronous reset clears configuration, aux1, aux2, modem-control, the flag and `pwr_off_o`. It leaves diagnostic, LED and system-control unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_region | input | 3 | Register region select |
| bus_offset | input | 2 | Byte offset inside the region |
| bus_size | input | 2 | 0 byte, 1 half, 2 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| pwr_failing_i | input | 1 | Power-failing status level |
| irq_o | output | 1 | Power-fail interrupt level |
| tc_pulse_o | output | 1 | Floppy terminal-count pulse |
| reset_req_o | output | 1 | System reset request pulse |
| pwr_off_o | output | 1 | Sticky power-off request |

## Verification
A flag that is wrongly set or cleared shows in the same cycle on `irq_o` whenever the enable is on. It also shows on any aux2 read, so a wrong edge or priority decision is visible one clock after the input change. A pulse that lasts too long, or fires from a masked write, is visible at the first clock after the write. Reads are combinational, so a wrong stored value or a size-decode error shows on the same cycle as the read. This includes registers that wrongly reset, which the bench probes right after each reset.

// File: rtl/aux_ctl_pkg.sv
// Package: region and size codes, control bit positions and the size each
// region accepts. Assumes a 3-bit region select and a 2-bit size code.
package aux_ctl_pkg;

    typedef enum logic [2:0] {
        RG_CFG   = 3'd0,
        RG_DIAG  = 3'd1,
        RG_MODEM = 3'd2,
        RG_AUX1  = 3'd3,
        RG_AUX2  = 3'd4,
        RG_LED   = 3'd5,
        RG_SYS   = 3'd6,
        RG_NONE  = 3'd7
    } region_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_NONE = 2'd3
    } size_e;

    localparam int NUM_REGIONS   = 7;
    localparam int PIE_BIT       = 3;
    localparam int TC_BIT        = 1;
    localparam int OFF_BIT       = 0;
    localparam int CLR_BIT       = 1;
    localparam int FLAG_BIT      = 5;
    localparam int SYS_KICK_BIT  = 0;
    localparam int SYS_STAT_BIT  = 1;

    // Access size that a region accepts.
    function automatic size_e region_size(input logic [2:0] rg);
        case (rg)
            RG_LED:  return SZ_HALF;
            RG_SYS:  return SZ_WORD;
            RG_NONE: return SZ_NONE;
            default: return SZ_BYTE;
        endcase
    endfunction

endpackage

// File: rtl/aux_bus_decode.sv
// Bus decode: validates offset and size against the addressed region and
// produces one write strobe per region plus a read-valid qualifier.
// Assumes a single-cycle access with no wait states.
module aux_bus_decode
    import aux_ctl_pkg::*;
#(
    parameter int NREG = NUM_REGIONS
) (
    input  logic            en,
    input  logic            we,
    input  logic [2:0]      region,
    input  logic [1:0]      offset,
    input  logic [1:0]      size,
    output logic [NREG-1:0] wr_stb,
    output logic            rd_ok
);
    logic acc_ok;

    // Access is legal when the offset is zero and the size fits the region.
    always_comb begin
        acc_ok = en && (offset == 2'd0) && (region != RG_NONE)
                 && (size == region_size(region));
        rd_ok  = acc_ok && !we;
    end

    for (genvar i = 0; i < NREG; i++) begin : g_stb
        // One write strobe per region.
        assign wr_stb[i] = acc_ok && we && (region == 3'(i));
    end
endmodule

// File: rtl/aux_pulse.sv
// Single-clock pulse register: the output is high for the clock after a
// trigger. Assumes the trigger is already qualified by the caller.
module aux_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic pulse
);
    // Register the trigger so the pulse is exactly one clock wide per trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse <= 1'b0;
        else        pulse <= trig;
    end
endmodule

// File: rtl/aux_pwr_ctl.sv
// Power-fail flag, power-off bit and sticky power-off request. The flag is
// re-evaluated on each change of the power-failing input and cleared by an
// aux2 clear write. Assumes pie_i comes from a register, so it holds its
// value from before this clock.
module aux_pwr_ctl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pf_i,
    input  logic       pie_i,
    input  logic       wr_i,
    input  logic [1:0] wbits_i,
    output logic       flag_o,
    output logic       off_bit_o,
    output logic       pwr_off_o,
    output logic       irq_o
);
    import aux_ctl_pkg::*;

    logic pf_prev_q;
    logic pf_change;

    // Detect a change of the power-failing input.
    always_comb pf_change = (pf_i != pf_prev_q);

    // Track the previous input value.
    always_ff @(posedge clk) begin
        if (!rst_n) pf_prev_q <= 1'b0;
        else        pf_prev_q <= pf_i;
    end

    // Flag update: an input change wins over a clear write.
    always_ff @(posedge clk) begin
        if (!rst_n)                         flag_o <= 1'b0;
        else if (pf_change)                 flag_o <= pf_i & pie_i;
        else if (wr_i && wbits_i[CLR_BIT])  flag_o <= 1'b0;
    end

    // Stored power-off bit, replaced on every aux2 write.
    always_ff @(posedge clk) begin
        if (!rst_n)    off_bit_o <= 1'b0;
        else if (wr_i) off_bit_o <= wbits_i[OFF_BIT];
    end

    // Sticky power-off request, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                         pwr_off_o <= 1'b0;
        else if (wr_i && wbits_i[OFF_BIT])  pwr_off_o <= 1'b1;
    end

    // Interrupt level from the flag and the enable.
    always_comb irq_o = flag_o & pie_i;
endmodule

// File: rtl/aux_ctl_bank.sv
// Top of the auxiliary control register bank. Holds the plain registers,
// the read multiplexer and the two pulse outputs. Assumes single-cycle
// accesses. Diagnostic, LED and system-control registers keep their value
// across reset.
module aux_ctl_bank
    import aux_ctl_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    parameter int LED_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [2:0]        bus_region,
    input  logic [1:0]        bus_offset,
    input  logic [1:0]        bus_size,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              pwr_failing_i,
    output logic              irq_o,
    output logic              tc_pulse_o,
    output logic              reset_req_o,
    output logic              pwr_off_o
);
    localparam logic [BYTE_W-1:0] SYS_STAT_VAL = BYTE_W'(1 << SYS_STAT_BIT);
    localparam logic [BYTE_W-1:0] TC_MASK      = ~BYTE_W'(1 << TC_BIT);

    logic [NUM_REGIONS-1:0] wr_stb;
    logic                   rd_ok;
    logic [BYTE_W-1:0]      cfg_q, diag_q, modem_q, aux1_q, sys_q;
    logic [LED_W-1:0]       led_q;
    logic                   pf_flag, off_bit;

    aux_bus_decode #(.NREG(NUM_REGIONS)) u_dec (
        .en     (bus_en),
        .we     (bus_we),
        .region (bus_region),
        .offset (bus_offset),
        .size   (bus_size),
        .wr_stb (wr_stb),
        .rd_ok  (rd_ok)
    );

    // Registers cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            modem_q <= '0;
            aux1_q  <= '0;
        end else begin
            if (wr_stb[RG_CFG])   cfg_q   <= bus_wdata[BYTE_W-1:0];
            if (wr_stb[RG_MODEM]) modem_q <= bus_wdata[BYTE_W-1:0];
            if (wr_stb[RG_AUX1])  aux1_q  <= bus_wdata[BYTE_W-1:0] & TC_MASK;
        end
    end

    // Registers that keep their contents across reset.
    always_ff @(posedge clk) begin
        if (wr_stb[RG_DIAG]) diag_q <= bus_wdata[BYTE_W-1:0];
        if (wr_stb[RG_LED])  led_q  <= bus_wdata[LED_W-1:0];
        if (wr_stb[RG_SYS] && bus_wdata[SYS_KICK_BIT]) sys_q <= SYS_STAT_VAL;
    end

    aux_pwr_ctl u_pwr (
        .clk       (clk),
        .rst_n     (rst_n),
        .pf_i      (pwr_failing_i),
        .pie_i     (cfg_q[PIE_BIT]),
        .wr_i      (wr_stb[RG_AUX2]),
        .wbits_i   (bus_wdata[1:0]),
        .flag_o    (pf_flag),
        .off_bit_o (off_bit),
        .pwr_off_o (pwr_off_o),
        .irq_o     (irq_o)
    );

    aux_pulse u_tc (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (wr_stb[RG_AUX1] && bus_wdata[TC_BIT]),
        .pulse (tc_pulse_o)
    );

    aux_pulse u_rst (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (wr_stb[RG_SYS] && bus_wdata[SYS_KICK_BIT]),
        .pulse (reset_req_o)
    );

    // Read multiplexer: zero unless a valid read is in progress.
    always_comb begin
        bus_rdata = '0;
        if (rd_ok) begin
            case (bus_region)
                RG_CFG:   bus_rdata = DATA_W'(cfg_q);
                RG_DIAG:  bus_rdata = DATA_W'(diag_q);
                RG_MODEM: bus_rdata = DATA_W'(modem_q);
                RG_AUX1:  bus_rdata = DATA_W'(aux1_q);
                RG_AUX2: begin
                    bus_rdata[FLAG_BIT] = pf_flag;
                    bus_rdata[OFF_BIT]  = off_bit;
                end
                RG_LED:   bus_rdata = DATA_W'(led_q);
                RG_SYS:   bus_rdata = DATA_W'(sys_q);
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/aux_ctl_bank_chk.sv
// Checker bound to the register bank: relates pulses, interrupts and read
// data to the bus activity that must cause them.
module aux_ctl_bank_chk
    import aux_ctl_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        bus_en,
    input logic        bus_we,
    input logic [2:0]  bus_region,
    input logic [1:0]  bus_offset,
    input logic [1:0]  bus_size,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        irq_o,
    input logic        tc_pulse_o,
    input logic        reset_req_o,
    input logic        pwr_off_o,
    input logic        pie
);
    logic legal;
    always_comb legal = bus_en && bus_offset == 2'd0 && bus_region != RG_NONE
                        && bus_size == region_size(bus_region);

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> pie); // R1
    AST_TC_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse_o |-> $past(legal && bus_we && bus_region == RG_AUX1 && bus_wdata[TC_BIT])); // R3
    AST_AUX1_BIT1_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (legal && !bus_we && bus_region == RG_AUX1) |-> !bus_rdata[TC_BIT]); // R3
    AST_PWROFF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_off_o |=> pwr_off_o); // R5
    AST_RSTREQ_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req_o |-> $past(legal && bus_we && bus_region == RG_SYS && bus_wdata[SYS_KICK_BIT])); // R6
    AST_BAD_ACCESS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !legal |-> bus_rdata == 32'd0); // R8
endmodule

bind aux_ctl_bank aux_ctl_bank_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_en      (bus_en),
    .bus_we      (bus_we),
    .bus_region  (bus_region),
    .bus_offset  (bus_offset),
    .bus_size    (bus_size),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .irq_o       (irq_o),
    .tc_pulse_o  (tc_pulse_o),
    .reset_req_o (reset_req_o),
    .pwr_off_o   (pwr_off_o),
    .pie         (cfg_q[3])
);

// File: tb/aux_ctl_bank_test.sv
`timescale 1ns/1ps
// Bench: directed corner cases then seeded random traffic, compared with a
// behavioural model of the requirements.
module aux_ctl_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [2:0]  bus_region = '0;
    logic [1:0]  bus_offset = '0, bus_size = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        pwr_failing_i = 1'b0;
    logic        irq_o, tc_pulse_o, reset_req_o, pwr_off_o;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // Model state.
    logic [7:0]  m_cfg, m_diag, m_modem, m_aux1, m_sys;
    logic [15:0] m_led;
    logic        m_flag, m_offb, m_poff, m_pf_prev;

    always #2 clk = ~clk;

    aux_ctl_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_region(bus_region), .bus_offset(bus_offset), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwr_failing_i(pwr_failing_i), .irq_o(irq_o), .tc_pulse_o(tc_pulse_o),
        .reset_req_o(reset_req_o), .pwr_off_o(pwr_off_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] esz(input logic [2:0] rg);
        if (rg == 3'd5) return 2'd1;
        if (rg == 3'd6) return 2'd2;
        return 2'd0;
    endfunction

    function automatic bit legal(input logic en, input logic [2:0] rg,
                                 input logic [1:0] off, input logic [1:0] sz);
        return en && off == 2'd0 && rg != 3'd7 && sz == esz(rg);
    endfunction

    function automatic string rtag(input bit ok, input logic [2:0] rg);
        if (!ok) return "R8 read of invalid access";
        case (rg)
            3'd3: return "R3 aux1 read";
            3'd4: return "R4 aux2 read";
            3'd6: return "R6 sysctl read";
            default: return "R7 plain register read";
        endcase
    endfunction

    function automatic logic [31:0] model_read(input bit ok, input logic we, input logic [2:0] rg);
        if (!ok || we) return 32'd0;
        case (rg)
            3'd0: return {24'd0, m_cfg};
            3'd1: return {24'd0, m_diag};
            3'd2: return {24'd0, m_modem};
            3'd3: return {24'd0, m_aux1};
            3'd4: return {26'd0, m_flag, 4'd0, m_offb};
            3'd5: return {16'd0, m_led};
            3'd6: return {24'd0, m_sys};
            default: return 32'd0;
        endcase
    endfunction

    // One bus cycle: drive at negedge, check read, clock, update model, check outputs.
    task automatic step(input logic en, input logic we, input logic [2:0] rg,
                        input logic [1:0] off, input logic [1:0] sz,
                        input logic [31:0] wd, input logic pf);
        bit ok, wr, chg, exp_tc, exp_rr, pie_old;
        bus_en = en; bus_we = we; bus_region = rg; bus_offset = off;
        bus_size = sz; bus_wdata = wd; pwr_failing_i = pf;
        ok = legal(en, rg, off, sz);
        #1;
        chk(rtag(ok, rg), bus_rdata, model_read(ok, we, rg));
        @(posedge clk);
        #1;
        wr = ok && we;
        chg = (pf != m_pf_prev);
        m_pf_prev = pf;
        pie_old = m_cfg[3];
        exp_tc = wr && rg == 3'd3 && wd[1];
        exp_rr = wr && rg == 3'd6 && wd[0];
        if (chg) m_flag = pf & pie_old;            // R2 change wins
        else if (wr && rg == 3'd4 && wd[1]) m_flag = 1'b0;
        if (wr) begin
            case (rg)
                3'd0: m_cfg = wd[7:0];
                3'd1: m_diag = wd[7:0];
                3'd2: m_modem = wd[7:0];
                3'd3: m_aux1 = wd[7:0] & 8'hFD;
                3'd4: begin m_offb = wd[0]; if (wd[0]) m_poff = 1'b1; end
                3'd5: m_led = wd[15:0];
                3'd6: if (wd[0]) m_sys = 8'h02;
                default: ;
            endcase
        end
        chk("R3 tc pulse", {31'd0, tc_pulse_o}, {31'd0, exp_tc});
        chk("R6 reset request pulse", {31'd0, reset_req_o}, {31'd0, exp_rr});
        chk("R1 irq level", {31'd0, irq_o}, {31'd0, m_flag & m_cfg[3]});
        chk("R5 power-off request", {31'd0, pwr_off_o}, {31'd0, m_poff});
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; bus_en = 1'b0; pwr_failing_i = 1'b0;
        @(posedge clk); @(posedge clk);
        #1;
        m_cfg = 0; m_modem = 0; m_aux1 = 0; m_flag = 0; m_offb = 0;
        m_poff = 0; m_pf_prev = 0;
        chk("R9 irq after reset", {31'd0, irq_o}, 32'd0);
        chk("R9 power-off after reset", {31'd0, pwr_off_o}, 32'd0);
        chk("R9 pulses after reset", {30'd0, tc_pulse_o, reset_req_o}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #700000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [2:0] rg; logic [1:0] sz, off; logic pf;
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();
        // Initialise the registers that reset leaves alone.
        step(1, 1, 3'd1, 0, 0, 32'h5A, 0);
        step(1, 1, 3'd5, 0, 1, 32'hBEEF, 0);
        step(1, 1, 3'd6, 0, 2, 32'h1, 0);               // R6 kick
        step(1, 0, 3'd6, 0, 2, 0, 0);
        step(1, 1, 3'd6, 0, 2, 32'hFFFF_FFFE, 0);       // R6 bit0 clear
        step(1, 0, 3'd6, 1, 2, 0, 0);                   // R8 offset 1
        // R1/R2: enable then failing edge sets flag and irq.
        step(1, 1, 3'd0, 0, 0, 32'h08, 0);
        step(0, 0, 3'd0, 0, 0, 0, 1);
        step(1, 0, 3'd4, 0, 0, 0, 1);
        // R4: clear bit clears flag, other bits ignored.
        step(1, 1, 3'd4, 0, 0, 32'hFE, 1);
        step(1, 0, 3'd4, 0, 0, 0, 1);
        // R2: enable off, input edges leave flag clear.
        step(1, 1, 3'd0, 0, 0, 32'h00, 0);
        step(1, 1, 3'd0, 0, 0, 32'h08, 1);
        step(1, 0, 3'd4, 0, 0, 0, 1);
        // R3: terminal count with bit 1 masked in storage.
        step(1, 1, 3'd3, 0, 0, 32'hFF, 1);
        step(1, 0, 3'd3, 0, 0, 0, 1);
        // R8: wrong size write ignored.
        step(1, 1, 3'd0, 0, 1, 32'h77, 1);
        step(1, 0, 3'd0, 0, 0, 0, 1);
        step(1, 1, 3'd7, 0, 3, 32'h1, 1);
        // R5: power-off sticky after bit0 written back to 0.
        step(1, 1, 3'd4, 0, 0, 32'h1, 0);
        step(1, 1, 3'd4, 0, 0, 32'h0, 0);
        step(1, 0, 3'd4, 0, 0, 0, 0);
        // R9: reset keeps diag, LED, sysctl; clears others.
        step(1, 1, 3'd2, 0, 0, 32'h33, 0);
        do_reset();
        step(1, 0, 3'd1, 0, 0, 0, 0);
        step(1, 0, 3'd5, 0, 1, 0, 0);
        step(1, 0, 3'd6, 0, 2, 0, 0);
        step(1, 0, 3'd2, 0, 0, 0, 0);
        step(1, 0, 3'd0, 0, 0, 0, 0);
        // Random traffic.
        pf = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            rg  = 3'($urandom % 8);
            sz  = ($urandom % 8 == 0) ? 2'($urandom % 4) : esz(rg);
            off = ($urandom % 8 == 0) ? 2'($urandom % 4) : 2'd0;
            if ($urandom % 12 == 0) pf = ~pf;
            if (i % 700 == 699) begin
                do_reset();
                pf = 1'b0;
            end
            step(($urandom % 8) != 0, 1'($urandom % 2), rg, off, sz, $urandom, pf);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule